// File: doc/BRIEF.md
# ADC Result DMA Request Generator

This block raises DMA requests for one conversion group of an ADC result buffer. It watches two strobes from the conversion side: one for each result written into the group's result memory, and one for the end of a full group conversion sequence. From these strobes and a 32-bit control register it produces a single-cycle request pulse for the DMA controller.

There are three request modes. In per-write mode, every result write raises a request. In block mode, a threshold counter counts result writes and raises one request after each run of a programmed number of results. In end-of-group mode, one request follows each completed group sequence. Block mode and end-of-group mode each override the per-write enable, and end-of-group mode wins when both are set. The current threshold count is brought out so that software and neighbouring logic can see it.

The control register has a plain write strobe and a combinational read-back. Mode changes are meant to be made before conversions start. A change made while conversions are running takes effect from the cycle after the register write.

Top module: `adc_dma_req_gen`

## Requirements
- R1: After reset, the request output, the threshold count and every read-back bit are 0.
- R2: Control layout: bit 0 is the per-write enable, bit 2 is the block enable, bit 3 is the end-of-group enable, and bits 24:16 hold the block count N. Bits 1, 15:4 and 31:25 always read 0, and writing them has no effect.
- R3: With bits 2 and 3 clear and bit 0 set, each result-write strobe gives exactly one request pulse.
- R4: With bit 2 set and bit 3 clear, the per-write enable is ignored. A request is issued on each result write that moves the threshold count from 1 to N. This gives one request per N writes, for N from 1 up to 2^CNT_W-1.
- R5: With N = 0, no block request is ever issued, and the threshold count stays 0.
- R6: With bit 3 set, the per-write enable and result writes are ignored, and each end-of-group strobe gives one request pulse.
- R7: With bits 2 and 3 both set, end-of-group behaviour applies. The threshold counter keeps counting result writes but raises no request.
- R8: A control write reloads the threshold count with the written N. A result write in the same cycle counts against that new value: the count becomes N-1, or N with a request when N = 1.
- R9: The request is a registered pulse that is high in the cycle after the causing strobe. Mode bits take effect from the cycle after the control write. The count updates in the same cycle as the request.
- R10: With bits 0, 2 and 3 all clear, no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read-back |
| res_wr_i | input | 1 | One result written to the group memory |
| grp_end_i | input | 1 | Group conversion sequence complete |
| dma_req_o | output | 1 | DMA request pulse |
| thr_cnt_o | output | CNT_W | Current threshold count |

## Verification
The bench builds the block with the default CNT_W of 9. This makes the largest block count, 511, reachable, and a full 511-write block fits in a few hundred cycles. The bench also runs the N = 1 case, where the reload value equals the terminal value, and the case where a control write and a result write land in the same cycle. A random phase then mixes register writes, result writes and end-of-group strobes, and checks the outputs against a behavioural model on every clock.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  // control bit positions; downstream decode depends on these
  localparam int unsigned WR_EN_BIT  = 0;
  localparam int unsigned BLK_EN_BIT = 2;
  localparam int unsigned EOG_EN_BIT = 3;
  localparam int unsigned BLK_LSB    = 16;
  localparam int unsigned REG_W      = 32;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_PER_WR = 2'd1,
    MODE_BLOCK  = 2'd2,
    MODE_EOG    = 2'd3
  } req_mode_e;
endpackage

// File: rtl/adc_dma_ctrl_reg.sv
module adc_dma_ctrl_reg
  import adc_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             wr_en_o,
  output logic             blk_en_o,
  output logic             eog_en_o,
  output logic [CNT_W-1:0] blk_nxt_o
);
  logic             wr_en_q, blk_en_q, eog_en_q;
  logic [CNT_W-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q  <= 1'b0;
      blk_en_q <= 1'b0;
      eog_en_q <= 1'b0;
      blk_q    <= '0;
    end else if (wr_i) begin
      wr_en_q  <= wdata_i[WR_EN_BIT];
      blk_en_q <= wdata_i[BLK_EN_BIT];
      eog_en_q <= wdata_i[EOG_EN_BIT];
      blk_q    <= wdata_i[BLK_LSB +: CNT_W];
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[WR_EN_BIT]          = wr_en_q;
    rdata_o[BLK_EN_BIT]         = blk_en_q;
    rdata_o[EOG_EN_BIT]         = eog_en_q;
    rdata_o[BLK_LSB +: CNT_W]   = blk_q;
  end

  assign wr_en_o   = wr_en_q;
  assign blk_en_o  = blk_en_q;
  assign eog_en_o  = eog_en_q;
  // block count in force this cycle, including a write landing now
  assign blk_nxt_o = wr_i ? wdata_i[BLK_LSB +: CNT_W] : blk_q;
endmodule

// File: rtl/adc_dma_thr_cnt.sv
module adc_dma_thr_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] blk_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, base, cnt_d;

  always_comb begin
    base  = load_i ? blk_i : cnt_q;
    hit_o = step_i && (base == ONE);
    cnt_d = base;
    if (step_i && base != '0) cnt_d = hit_o ? blk_i : base - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_dma_req_sel.sv
module adc_dma_req_sel
  import adc_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic blk_en_i,
  input  logic eog_en_i,
  input  logic res_wr_i,
  input  logic grp_end_i,
  input  logic hit_i,
  output logic req_o
);
  req_mode_e mode;
  logic      req_d, req_q;

  always_comb begin
    if (eog_en_i)      mode = MODE_EOG;
    else if (blk_en_i) mode = MODE_BLOCK;
    else if (wr_en_i)  mode = MODE_PER_WR;
    else               mode = MODE_OFF;
  end

  always_comb begin
    unique case (mode)
      MODE_EOG:    req_d = grp_end_i;
      MODE_BLOCK:  req_d = hit_i;
      MODE_PER_WR: req_d = res_wr_i;
      default:     req_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/adc_dma_req_gen.sv
module adc_dma_req_gen
  import adc_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             res_wr_i,
  input  logic             grp_end_i,
  output logic             dma_req_o,
  output logic [CNT_W-1:0] thr_cnt_o
);
  logic             wr_en, blk_en, eog_en, hit;
  logic [CNT_W-1:0] blk_nxt;

  adc_dma_ctrl_reg #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .wr_en_o  (wr_en),
    .blk_en_o (blk_en),
    .eog_en_o (eog_en),
    .blk_nxt_o(blk_nxt)
  );

  adc_dma_thr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(reg_wr_i),
    .blk_i (blk_nxt),
    .step_i(res_wr_i),
    .cnt_o (thr_cnt_o),
    .hit_o (hit)
  );

  adc_dma_req_sel u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .blk_en_i (blk_en),
    .eog_en_i (eog_en),
    .res_wr_i (res_wr_i),
    .grp_end_i(grp_end_i),
    .hit_i    (hit),
    .req_o    (dma_req_o)
  );
endmodule

// File: rtl/adc_dma_req_gen_chk.sv
module adc_dma_req_gen_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [31:0]      reg_wdata_i,
  input logic [31:0]      reg_rdata_o,
  input logic             res_wr_i,
  input logic             grp_end_i,
  input logic             dma_req_o,
  input logic [CNT_W-1:0] thr_cnt_o
);
  logic             m_wr, m_blk, m_eog;
  logic [CNT_W-1:0] m_n;
  assign m_wr  = reg_rdata_o[0];
  assign m_blk = reg_rdata_o[2];
  assign m_eog = reg_rdata_o[3];
  assign m_n   = reg_rdata_o[16 +: CNT_W];

  assert_per_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m_eog && !m_blk && m_wr && res_wr_i) |=> dma_req_o);

  assert_zero_n_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m_eog && m_blk && m_n == '0 && !reg_wr_i) |=> !dma_req_o);

  assert_eog_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_eog && grp_end_i) |=> dma_req_o);

  assert_eog_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_eog && !grp_end_i) |=> !dma_req_o);

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !res_wr_i) |=> thr_cnt_o == $past(reg_wdata_i[16 +: CNT_W]));

  assert_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(res_wr_i || grp_end_i));

  assert_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m_eog && !m_blk && !m_wr) |=> !dma_req_o);
endmodule

bind adc_dma_req_gen adc_dma_req_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_adc_dma_req_gen.sv
module sim_adc_dma_req_gen;
  localparam int CNT_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             res_wr = 1'b0;
  logic             grp_end = 1'b0;
  logic             dma_req;
  logic [CNT_W-1:0] thr_cnt;

  int n_run = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_wr = 0, m_blk = 0, m_eog = 0, m_n = 0, m_cnt = 0, m_req = 0;

  always #2 clk = ~clk;

  adc_dma_req_gen #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .res_wr_i(res_wr), .grp_end_i(grp_end),
    .dma_req_o(dma_req), .thr_cnt_o(thr_cnt)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    return (m_n << 16) | (m_eog << 3) | (m_blk << 2) | m_wr;
  endfunction

  // one clock: drive at low phase, model, sample 1 ns after the edge
  task automatic step(string tag, bit we, logic [31:0] wd, bit rw, bit ge);
    int nn, base, hit;
    reg_wr = we; reg_wdata = wd; res_wr = rw; grp_end = ge;
    @(posedge clk);
    nn   = we ? int'(wd[24:16]) : m_n;
    base = we ? nn : m_cnt;
    hit  = (rw && base == 1) ? 1 : 0;
    if (m_eog != 0)      m_req = ge;
    else if (m_blk != 0) m_req = hit;
    else                 m_req = (m_wr != 0 && rw) ? 1 : 0;
    m_cnt = (rw && base != 0) ? ((base == 1) ? nn : base - 1) : base;
    if (we) begin m_wr = wd[0]; m_blk = wd[2]; m_eog = wd[3]; m_n = nn; end
    #1;
    chk(tag, "dma_req", int'(dma_req), m_req);
    chk(tag, "thr_cnt", int'(thr_cnt), m_cnt);
    chk(tag, "rdata", int'(reg_rdata), exp_rdata());
    @(negedge clk);
  endtask

  task automatic cfg(string tag, logic [31:0] wd);
    step(tag, 1'b1, wd, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    #5;
    @(negedge clk);
    // R1 reset state
    chk("R1", "dma_req", int'(dma_req), 0);
    chk("R1", "thr_cnt", int'(thr_cnt), 0);
    chk("R1", "rdata", int'(reg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reserved bits: all ones write reads back only defined fields
    cfg("R2", 32'hFFFF_FFFF);
    chk("R2", "rdata_mask", int'(reg_rdata), 32'h01FF_000D);
    cfg("R2", 32'hFE00_FFF2);
    chk("R2", "rdata_rsvd", int'(reg_rdata), 0);

    // R10 everything off
    for (int i = 0; i < 6; i++) step("R10", 1'b0, '0, 1'b1, i[0]);

    // R3 per-write, bursts and gaps; R9 timing checked each step
    cfg("R3", 32'h0000_0001);
    for (int i = 0; i < 12; i++) step("R3", 1'b0, '0, (i % 3) != 2, i == 5);

    // R4 block of 3, per-write enable also set and ignored
    cfg("R4", 32'h0003_0005);
    pulses = 0;
    for (int i = 0; i < 12; i++) begin
      step("R4", 1'b0, '0, 1'b1, i == 4);
      pulses += int'(dma_req);
    end
    chk("R4", "pulses_per_12", pulses, 4);

    // R4 N = 1: every write requests
    cfg("R4", 32'h0001_0004);
    for (int i = 0; i < 5; i++) step("R4", 1'b0, '0, 1'b1, 1'b0);

    // R4 N = 511 (maximum)
    cfg("R4", 32'h01FF_0004);
    pulses = 0;
    for (int i = 0; i < 1100; i++) begin
      step("R4", 1'b0, '0, (i % 7) != 3, 1'b0);
      pulses += int'(dma_req);
    end
    chk("R4", "pulses_n511", pulses, 1);

    // R5 N = 0: nothing
    cfg("R5", 32'h0000_0005);
    for (int i = 0; i < 8; i++) step("R5", 1'b0, '0, 1'b1, 1'b0);

    // R6 end-of-group with per-write noise
    cfg("R6", 32'h0000_0009);
    for (int i = 0; i < 10; i++) step("R6", 1'b0, '0, 1'b1, (i % 4) == 1);

    // R7 both overrides: counter runs, no block pulses
    cfg("R7", 32'h0002_000D);
    for (int i = 0; i < 9; i++) step("R7", 1'b0, '0, 1'b1, i == 6);

    // R8 reload with concurrent result write
    cfg("R8", 32'h0005_0004);
    step("R8", 1'b0, '0, 1'b1, 1'b0);
    step("R8", 1'b1, 32'h0004_0004, 1'b1, 1'b0);
    chk("R8", "cnt_after_load_step", int'(thr_cnt), 3);
    step("R8", 1'b1, 32'h0001_0004, 1'b1, 1'b0);
    chk("R8", "req_on_n1_load", int'(dma_req), 1);
    step("R8", 1'b1, 32'h0006_0004, 1'b0, 1'b0);
    chk("R8", "cnt_reload", int'(thr_cnt), 6);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      automatic logic [31:0] r = $urandom;
      automatic bit w = ($urandom % 40) == 0;
      automatic logic [31:0] wd = {7'h0, 9'(r[8:0] % 9), 12'h0, r[15:12]};
      step("R9", w, wd, $urandom % 3 != 0, $urandom % 5 == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule